// File: doc/BRIEF.md
# Presettable Synchronous Up/Down Counter Stage

This block is a single counter stage that moves one step per rising clock edge, either upward or downward as a direction input selects. A build-time option picks the sequence: a decimal digit that runs 0 to 9, or a plain binary word that uses every code of its width. A synchronous load copies a preset word into the state. Two active-low enables gate counting. The first is meant to be shared by every stage of a chain. The second is meant to be fed by the previous stage's terminal flag.

The terminal flag is active low and purely combinational. It depends on the present state, the direction and the chain enable. This lets several stages be linked with carry lookahead inside a single clock period. In decimal mode the six codes above 9 are not part of the sequence. Each of them has a fixed successor, so a stage loaded with such a code returns to the digit range within two counting steps.

Top module: `updn_preset_counter`

## Requirements
- R1: While `load_n` is 0, the rising clock edge copies `preset` into `count`, whatever the values of `en_par_n`, `en_chain_n` and `up`; the state changes only on rising edges.
- R2: When `load_n`=1, `en_par_n`=0, `en_chain_n`=0 and `up`=1, an in-range state below the sequence end advances by one on the edge.
- R3: When `load_n`=1, `en_par_n`=0, `en_chain_n`=0 and `up`=0, an in-range nonzero state goes down by one on the edge.
- R4: When `load_n`=1 and either `en_par_n` or `en_chain_n` is 1, `count` keeps its value across the edge.
- R5: Wraparound: binary mode goes 15 to 0 upward and 0 to 15 downward; decimal mode goes 9 to 0 upward and 0 to 9 downward.
- R6: `term_n` is 1 whenever `en_chain_n` is 1. With `en_chain_n`=0 it is 0 exactly when `up`=0 and `count`=0, or when `up`=1 and the state is at the top: all ones in binary mode, and bit 0 and bit 3 both set in decimal mode (so the codes 9, 11, 13 and 15 qualify). It reacts in the same cycle and does not depend on `en_par_n`.
- R7: In decimal mode, counting up maps 10 to 11, 11 to 6, 12 to 13, 13 to 4, 14 to 15 and 15 to 2. Counting down maps 10 to 9, 11 to 10, 12 to 3, 13 to 12, 14 to 5 and 15 to 14.
- R8: In decimal mode, from any code 10 to 15, at most two counting steps in either direction bring `count` into 0 to 9.
- R9: When a stage's `term_n` drives the next stage's `en_chain_n` and `en_par_n` is shared, two stages count as one two-digit decimal counter (0 to 99) or one 8-bit binary counter (0 to 255), in both directions.
- R10: The build fails when decimal mode is chosen with a width other than 4, or when the width is below 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| load_n | input | 1 | Active-low synchronous load of `preset` |
| en_par_n | input | 1 | Active-low count enable, shared across a chain |
| en_chain_n | input | 1 | Active-low count enable that also gates `term_n` |
| up | input | 1 | Direction: 1 increments, 0 decrements |
| preset | input | WIDTH | Word loaded when `load_n` is 0 |
| count | output | WIDTH | Present counter state |
| term_n | output | 1 | Active-low terminal flag, combinational |

## Verification
The block has no reset input, so its state is unknown until the first load. The checker stays idle until it has seen an edge with `load_n` low. Its assertions also assume that every control input holds a defined 0 or 1 at each edge. The bench drives all inputs to known values from time zero, and its first action on each stage is a load. This means every property starts from a defined state. Out-of-range decimal codes are entered only by loading them, which is the case the recovery property covers.

// File: rtl/upc_pkg.sv
package upc_pkg;

   // Operation selected for the next rising edge
   typedef enum logic [1:0] {
      UPC_HOLD = 2'd0,
      UPC_LOAD = 2'd1,
      UPC_INC  = 2'd2,
      UPC_DEC  = 2'd3
   } upc_op_e;

   localparam int unsigned UPC_DIGIT_W   = 4;
   localparam int unsigned UPC_DIGIT_TOP = 9;

   // Upward successor of a decimal digit, unused codes included
   function automatic logic [3:0] upc_digit_up(input logic [3:0] v);
      logic [3:0] r;
      case (v)
         4'd9:    r = 4'd0;
         4'd11:   r = 4'd6;
         4'd13:   r = 4'd4;
         4'd15:   r = 4'd2;
         default: r = v + 4'd1;
      endcase
      return r;
   endfunction

   // Downward successor of a decimal digit, unused codes included
   function automatic logic [3:0] upc_digit_dn(input logic [3:0] v);
      logic [3:0] r;
      case (v)
         4'd0:    r = 4'd9;
         4'd12:   r = 4'd3;
         4'd14:   r = 4'd5;
         default: r = v - 4'd1;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/upc_mode_dec.sv
module upc_mode_dec
   import upc_pkg::*;
(
   input  logic    load_n,
   input  logic    en_par_n,
   input  logic    en_chain_n,
   input  logic    up,
   output upc_op_e op
);

   // Load wins over everything; counting needs both enables low
   always_comb begin
      if (!load_n)
         op = UPC_LOAD;
      else if (en_par_n || en_chain_n)
         op = UPC_HOLD;
      else if (up)
         op = UPC_INC;
      else
         op = UPC_DEC;
   end

endmodule

// File: rtl/upc_step.sv
module upc_step
   import upc_pkg::*;
#(
   parameter int unsigned WIDTH   = 4,
   parameter bit          DECIMAL = 1'b1
) (
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] nxt_inc,
   output logic [WIDTH-1:0] nxt_dec
);

   generate
      if (DECIMAL) begin : g_digit
         // Width fixed to UPC_DIGIT_W by the top-level check
         assign nxt_inc = upc_digit_up(cur);
         assign nxt_dec = upc_digit_dn(cur);
      end else begin : g_binary
         // Natural modulo-2^WIDTH wrap
         assign nxt_inc = cur + WIDTH'(1);
         assign nxt_dec = cur - WIDTH'(1);
      end
   endgenerate

endmodule

// File: rtl/upc_term.sv
module upc_term #(
   parameter int unsigned WIDTH   = 4,
   parameter bit          DECIMAL = 1'b1
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             up,
   input  logic             en_chain_n,
   output logic             term_n
);

   logic at_top;
   logic at_floor;

   assign at_floor = ~|cur;

   generate
      if (DECIMAL) begin : g_digit
         // Partial decode: 9 plus unused codes 11, 13, 15
         assign at_top = cur[0] & cur[WIDTH-1];
      end else begin : g_binary
         assign at_top = &cur;
      end
   endgenerate

   assign term_n = ~(~en_chain_n & (up ? at_top : at_floor));

endmodule

// File: rtl/updn_preset_counter.sv
module updn_preset_counter
   import upc_pkg::*;
#(
   parameter int unsigned WIDTH   = 4,
   parameter bit          DECIMAL = 1'b1
) (
   input  logic             clk,
   input  logic             load_n,
   input  logic             en_par_n,
   input  logic             en_chain_n,
   input  logic             up,
   input  logic [WIDTH-1:0] preset,
   output logic [WIDTH-1:0] count,
   output logic             term_n
);

   // Elaboration-time parameter checks (R10)
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("updn_preset_counter: WIDTH must be at least 1");
      end
      if (DECIMAL && (WIDTH != UPC_DIGIT_W)) begin : g_bad_digit
         $error("updn_preset_counter: decimal mode needs WIDTH of 4");
      end
   endgenerate

   upc_op_e          op;
   logic [WIDTH-1:0] nxt_inc;
   logic [WIDTH-1:0] nxt_dec;
   logic [WIDTH-1:0] state_q;

   upc_mode_dec mode_i (
      .load_n     (load_n),
      .en_par_n   (en_par_n),
      .en_chain_n (en_chain_n),
      .up         (up),
      .op         (op)
   );

   upc_step #(.WIDTH(WIDTH), .DECIMAL(DECIMAL)) step_i (
      .cur     (state_q),
      .nxt_inc (nxt_inc),
      .nxt_dec (nxt_dec)
   );

   upc_term #(.WIDTH(WIDTH), .DECIMAL(DECIMAL)) term_i (
      .cur        (state_q),
      .up         (up),
      .en_chain_n (en_chain_n),
      .term_n     (term_n)
   );

   // Single state register; no reset, first load defines it
   always_ff @(posedge clk) begin
      unique case (op)
         UPC_LOAD: state_q <= preset;
         UPC_INC:  state_q <= nxt_inc;
         UPC_DEC:  state_q <= nxt_dec;
         default:  state_q <= state_q;
      endcase
   end

   assign count = state_q;

endmodule

// File: rtl/updn_preset_counter_chk.sv
module updn_preset_counter_chk #(
   parameter int unsigned WIDTH   = 4,
   parameter bit          DECIMAL = 1'b1
) (
   input logic             clk,
   input logic             load_n,
   input logic             en_par_n,
   input logic             en_chain_n,
   input logic             up,
   input logic [WIDTH-1:0] preset,
   input logic [WIDTH-1:0] count,
   input logic             term_n
);

   localparam logic [WIDTH-1:0] LAST = DECIMAL ? WIDTH'(9) : {WIDTH{1'b1}};

   // No reset exists: stay idle until the first load defines the state
   logic primed = 1'b0;
   always_ff @(posedge clk) begin
      if (!load_n)
         primed <= 1'b1;
   end

   logic stepping;
   logic legal;
   assign stepping = load_n & ~en_par_n & ~en_chain_n;
   assign legal    = !DECIMAL || (count <= WIDTH'(9));

   assert_load_R1: assert property (@(posedge clk) disable iff (!primed)
      !load_n |=> count == $past(preset));

   assert_inc_R2: assert property (@(posedge clk) disable iff (!primed)
      stepping && up && legal && (count != LAST) |=> count == $past(count) + WIDTH'(1));

   assert_dec_R3: assert property (@(posedge clk) disable iff (!primed)
      stepping && !up && legal && (count != '0) |=> count == $past(count) - WIDTH'(1));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!primed)
      load_n && (en_par_n || en_chain_n) |=> $stable(count));

   assert_wrap_up_R5: assert property (@(posedge clk) disable iff (!primed)
      stepping && up && (count == LAST) |=> count == '0);

   assert_wrap_dn_R5: assert property (@(posedge clk) disable iff (!primed)
      stepping && !up && (count == '0) |=> count == LAST);

   assert_term_idle_R6: assert property (@(posedge clk) disable iff (!primed)
      en_chain_n |-> term_n);

   assert_term_floor_R6: assert property (@(posedge clk) disable iff (!primed)
      !en_chain_n && !up |-> term_n == (count != '0));

   generate
      if (DECIMAL) begin : g_digit
         assert_term_top_R6: assert property (@(posedge clk) disable iff (!primed)
            !en_chain_n && up |-> term_n == !(count[0] && count[WIDTH-1]));

         assert_recover_R8: assert property (@(posedge clk) disable iff (!primed)
            (stepping && !legal) ##1 (stepping && !legal) |=> legal);
      end else begin : g_binary
         assert_term_top_R6: assert property (@(posedge clk) disable iff (!primed)
            !en_chain_n && up |-> term_n == (count != LAST));
      end
   endgenerate

endmodule

bind updn_preset_counter updn_preset_counter_chk #(.WIDTH(WIDTH), .DECIMAL(DECIMAL)) chk_i (
   .clk        (clk),
   .load_n     (load_n),
   .en_par_n   (en_par_n),
   .en_chain_n (en_chain_n),
   .up         (up),
   .preset     (preset),
   .count      (count),
   .term_n     (term_n)
);

// File: tb/updn_preset_counter_tb_top.sv
`timescale 1ns/1ps
module updn_preset_counter_tb_top;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // Shared stimulus for the single-stage sweep
   logic       load_n = 1'b1, en_par_n = 1'b1, en_chain_n = 1'b1, up = 1'b1;
   logic [3:0] preset = 4'd0;
   logic [3:0] dq, bq;
   logic       dt_n, bt_n;

   updn_preset_counter #(.WIDTH(4), .DECIMAL(1'b1)) dut_i (
      .clk(clk), .load_n(load_n), .en_par_n(en_par_n), .en_chain_n(en_chain_n),
      .up(up), .preset(preset), .count(dq), .term_n(dt_n));

   updn_preset_counter #(.WIDTH(4), .DECIMAL(1'b0)) bin_i (
      .clk(clk), .load_n(load_n), .en_par_n(en_par_n), .en_chain_n(en_chain_n),
      .up(up), .preset(preset), .count(bq), .term_n(bt_n));

   // Cascade stimulus (R9)
   logic       c_load_n = 1'b1, c_par_n = 1'b1, c_chain_n = 1'b1, c_up = 1'b1;
   logic [3:0] c_pre_lo = 4'd0, c_pre_hi = 4'd0;
   logic [3:0] dlo_q, dhi_q, blo_q, bhi_q;
   logic       dlo_t, dhi_t, blo_t, bhi_t;

   updn_preset_counter #(.WIDTH(4), .DECIMAL(1'b1)) dlo_i (
      .clk(clk), .load_n(c_load_n), .en_par_n(c_par_n), .en_chain_n(c_chain_n),
      .up(c_up), .preset(c_pre_lo), .count(dlo_q), .term_n(dlo_t));
   updn_preset_counter #(.WIDTH(4), .DECIMAL(1'b1)) dhi_i (
      .clk(clk), .load_n(c_load_n), .en_par_n(c_par_n), .en_chain_n(dlo_t),
      .up(c_up), .preset(c_pre_hi), .count(dhi_q), .term_n(dhi_t));
   updn_preset_counter #(.WIDTH(4), .DECIMAL(1'b0)) blo_i (
      .clk(clk), .load_n(c_load_n), .en_par_n(c_par_n), .en_chain_n(c_chain_n),
      .up(c_up), .preset(c_pre_lo), .count(blo_q), .term_n(blo_t));
   updn_preset_counter #(.WIDTH(4), .DECIMAL(1'b0)) bhi_i (
      .clk(clk), .load_n(c_load_n), .en_par_n(c_par_n), .en_chain_n(blo_t),
      .up(c_up), .preset(c_pre_hi), .count(bhi_q), .term_n(bhi_t));

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // Unused decimal successors as given in R7
   function automatic int odd_up(input int q);
      case (q)
         10: return 11; 11: return 6; 12: return 13;
         13: return 4;  14: return 15; default: return 2;
      endcase
   endfunction
   function automatic int odd_dn(input int q);
      case (q)
         10: return 9;  11: return 10; 12: return 3;
         13: return 12; 14: return 5;  default: return 14;
      endcase
   endfunction

   function automatic int ref_next(input bit dec, input int q, input bit ld, input bit ep,
                                   input bit et, input bit u, input int d);
      if (!ld) return d;
      if (ep || et) return q;
      if (dec) begin
         if (q > 9) return u ? odd_up(q) : odd_dn(q);
         if (u) return (q + 1) % 10;
         return (q + 9) % 10;
      end
      if (u) return (q + 1) % 16;
      return (q + 15) % 16;
   endfunction

   function automatic int ref_term(input bit dec, input int q, input bit et, input bit u);
      if (et) return 1;
      if (!u) return (q == 0) ? 0 : 1;
      if (dec) return ((q % 2 == 1) && (q >= 8)) ? 0 : 1;
      return (q == 15) ? 0 : 1;
   endfunction

   function automatic string tag_of(input bit dec, input int q, input bit ld, input bit ep,
                                    input bit et, input bit u);
      if (!ld) return "R1 load";
      if (ep || et) return "R4 hold";
      if (dec && q > 9) return "R7 unused successor";
      if (u && q == (dec ? 9 : 15)) return "R5 wrap up";
      if (!u && q == 0) return "R5 wrap down";
      return u ? "R2 increment" : "R3 decrement";
   endfunction

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      report();
   end

   initial begin
      // Initial state after first load, both modes (R1)
      @(negedge clk);
      load_n = 1'b0; preset = 4'd5;
      @(posedge clk); #1;
      chk("R1 first load decimal", dq, 5);
      chk("R1 first load binary", bq, 5);

      // Sweep every state against every control combination
      for (int s = 0; s < 16; s++) begin
         for (int c = 0; c < 16; c++) begin
            bit ld, ep, et, u;
            int dd;
            ld = c[0]; ep = c[1]; et = c[2]; u = c[3];
            dd = (s * 7 + c + 3) % 16;
            @(negedge clk);
            load_n = 1'b0; en_par_n = 1'b1; en_chain_n = 1'b1; preset = 4'(s);
            @(negedge clk);
            load_n = ld; en_par_n = ep; en_chain_n = et; up = u; preset = 4'(dd);
            #1;
            chk("R6 term decimal", dt_n, ref_term(1'b1, s, et, u));
            chk("R6 term binary", bt_n, ref_term(1'b0, s, et, u));
            @(posedge clk); #1;
            chk(tag_of(1'b1, s, ld, ep, et, u), dq, ref_next(1'b1, s, ld, ep, et, u, dd));
            chk(tag_of(1'b0, s, ld, ep, et, u), bq, ref_next(1'b0, s, ld, ep, et, u, dd));
            // R1: no change between edges
            #2;
            chk("R1 stable between edges", dq, ref_next(1'b1, s, ld, ep, et, u, dd));
         end
      end

      // Recovery from unused decimal codes within two steps (R8)
      for (int s = 10; s < 16; s++) begin
         for (int u = 0; u < 2; u++) begin
            @(negedge clk);
            load_n = 1'b0; preset = 4'(s);
            @(negedge clk);
            load_n = 1'b1; en_par_n = 1'b0; en_chain_n = 1'b0; up = u[0];
            repeat (2) @(posedge clk);
            #1;
            chk("R8 recovery within two steps", (dq <= 4'd9) ? 1 : 0, 1);
         end
      end

      // Cascades: decimal two-digit and 8-bit binary (R9)
      for (int u = 0; u < 2; u++) begin
         @(negedge clk);
         c_load_n = 1'b0; c_pre_lo = 4'd0; c_pre_hi = 4'd0; c_par_n = 1'b0; c_chain_n = 1'b0;
         @(negedge clk);
         c_load_n = 1'b1; c_up = u[0];
         for (int k = 1; k <= 300; k++) begin
            int ed, eb;
            @(posedge clk); #1;
            ed = u ? (k % 100) : ((100 - (k % 100)) % 100);
            eb = u ? (k % 256) : ((256 - (k % 256)) % 256);
            if (k <= 150) chk("R9 decimal cascade", int'(dhi_q) * 10 + int'(dlo_q), ed);
            chk("R9 binary cascade", int'(bhi_q) * 16 + int'(blo_q), eb);
         end
         // Chain enable high freezes both stages (R9, R4)
         @(negedge clk);
         c_chain_n = 1'b1;
         @(posedge clk); #1;
         chk("R9 cascade hold binary", int'(bhi_q) * 16 + int'(blo_q), u ? 44 : 212);
      end

      report();
   end

endmodule